// File: doc/BRIEF.md
# Display Data Channel Mode Controller

This block decides which of two signalling modes a monitor's display data channel is in. At power-up the channel is in the legacy mode, where the host clocks data out using vertical sync pulses. It moves to the bidirectional two-wire mode as soon as the host pulls the serial clock line low. The controller watches three inputs: the asynchronous serial clock level, the asynchronous vertical sync line, and a one-cycle indication from the serial slave that a matching device address was received. From these it keeps a mode flag and a lock flag that other logic reads.

Vertical sync pulses are counted while the clock line stays high and no valid address has arrived. When the count reaches a limit (128 by default), the controller locks into the two-wire mode. From then on it ignores vertical sync. A control bit, driven from a register elsewhere, holds the controller in its initial state while it is set. When the bit is cleared, the controller starts again from the legacy mode.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_2b` is 0 (legacy mode) and `locked` is 0.
- R2: A low level on `scl_async` that the synchronizer samples sets `mode_2b` to 1. It stays 1 until the software reset, and no other output changes because of it.
- R3: When 128 synchronized rising edges of `vsync_async` are counted while synchronized SCL is high, `addr_valid` is low and no clear has occurred, `locked` and `mode_2b` both become 1.
- R4: 127 such rising edges do not set `locked`.
- R5: Whenever synchronized SCL is low, the pulse count returns to zero, so earlier pulses do not add to later ones.
- R6: A cycle with `addr_valid` = 1 returns the pulse count to zero. If it falls in the same cycle as a qualifying edge, the clear wins and that edge is not counted.
- R7: Once `locked` is 1, activity on `scl_async` and `vsync_async` has no effect: `locked` and `mode_2b` stay 1.
- R8: While `soft_rst` is 1, `mode_2b`, `locked` and the count are held at 0. Counting resumes from zero on the cycle after `soft_rst` returns to 0.
- R9: Each asynchronous input passes through two synchronizer flops. A change on `scl_async` driven before a clock edge shows on `mode_2b` after the third following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_async | input | 1 | Serial clock line level, asynchronous |
| vsync_async | input | 1 | Vertical sync line, asynchronous |
| addr_valid | input | 1 | One-cycle pulse: a matching device address was received |
| soft_rst | input | 1 | Reset-channel control bit; holds the initial state while 1 |
| mode_2b | output | 1 | 1 = two-wire mode, 0 = legacy mode |
| locked | output | 1 | 1 = locked into two-wire mode; vertical sync ignored |

## Verification
Two events can fall in the same cycle: the qualifying vertical sync edge that would complete the count, and a clear caused by `addr_valid`. The bench also lines up the software reset with the locking edge. To provoke the first case, it sends 127 pulses and then holds `addr_valid` high across the 128th synchronized edge. It judges the result by comparing `locked` with a behavioural model on every clock, and then confirms that a fresh run of 128 pulses is needed before the lock sets.

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl #(
  parameter int LOCK_PULSES = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_async,
  input  logic vsync_async,
  input  logic addr_valid,
  input  logic soft_rst,
  output logic mode_2b,
  output logic locked
);
  localparam int CW = $clog2(LOCK_PULSES + 1);

  logic [SYNC_STAGES-1:0] scl_sy, vs_sy;
  logic                   vs_d;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      vs_sy  <= '0;
      vs_d   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_async};
      vs_sy  <= {vs_sy[SYNC_STAGES-2:0], vsync_async};
      vs_d   <= vs_sy[SYNC_STAGES-1];
    end

  wire scl_hi   = scl_sy[SYNC_STAGES-1];
  wire vs_rise  = vs_sy[SYNC_STAGES-1] & ~vs_d;
  wire clr      = ~scl_hi | addr_valid;
  wire count_en = vs_rise & scl_hi & ~addr_valid & ~locked;
  wire hit      = count_en && (cnt == CW'(LOCK_PULSES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      locked  <= 1'b0;
      mode_2b <= 1'b0;
    end else if (soft_rst) begin
      cnt     <= '0;
      locked  <= 1'b0;
      mode_2b <= 1'b0;
    end else begin
      if (clr)                        cnt <= '0;
      else if (count_en && cnt != '1) cnt <= cnt + 1'b1;
      if (hit)                        locked <= 1'b1;
      if (!scl_hi || hit)             mode_2b <= 1'b1;
    end
endmodule

module ddc_mode_ctrl_chk #(
  parameter int LOCK_PULSES = 128,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          addr_valid,
  input logic          mode_2b,
  input logic          locked,
  input logic [CW-1:0] cnt
);
  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_2b && !soft_rst) |=> mode_2b);
  // R3
  lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> mode_2b);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOCK_PULSES));
  // R6
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !locked) |=> (cnt == '0));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !soft_rst) |=> locked);
  // R8
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!mode_2b && !locked && cnt == '0));
endmodule

bind ddc_mode_ctrl ddc_mode_ctrl_chk #(.LOCK_PULSES(LOCK_PULSES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr_valid(addr_valid),
  .mode_2b(mode_2b), .locked(locked), .cnt(cnt)
);

// File: tb/ddc_mode_ctrl_test.sv
module ddc_mode_ctrl_test;
  logic clk = 0, rst_n = 0, scl = 1, vs = 0, av = 0, srst = 0;
  logic mode_2b, locked;
  int tests = 0, fails = 0, cyc = 0;
  string req = "R1";
  bit done = 0;

  int m_mode = 0, m_lock = 0, m_cnt = 0;
  int s0 = 1, s1 = 1, v0 = 0, v1 = 0, v2 = 0;

  always #2.5 clk = ~clk;

  ddc_mode_ctrl uut (.clk(clk), .rst_n(rst_n), .scl_async(scl), .vsync_async(vs),
                     .addr_valid(av), .soft_rst(srst), .mode_2b(mode_2b), .locked(locked));

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (srst) begin
        m_mode = 0; m_lock = 0; m_cnt = 0;
      end else begin
        if (s1 == 0) m_mode = 1;
        if (s1 == 0 || av) m_cnt = 0;
        else if (m_lock == 0 && v1 == 1 && v2 == 0) begin
          m_cnt++;
          if (m_cnt == 128) begin m_lock = 1; m_mode = 1; end
        end
      end
      v2 = v1; v1 = v0; v0 = vs;
      s1 = s0; s0 = scl;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (mode_2b !== m_mode[0] || locked !== m_lock[0]) begin
      fails++;
      $display("FAIL %s: mode_2b=%b locked=%b expected mode_2b=%0d locked=%0d",
               req, mode_2b, locked, m_mode, m_lock);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      vs = 1; step(2); vs = 0; step(2);
    end
  endtask

  task automatic expect_lock(int e);
    step(4);
    tests++;
    if (locked !== e[0]) begin
      fails++;
      $display("FAIL %s: locked=%b expected %0d", req, locked, e);
    end
  endtask

  task automatic soft_reset();
    req = "R8"; srst = 1; step(3); srst = 0; step(2);
  endtask

  initial begin
    step(3); rst_n = 1; step(3);
    req = "R1"; expect_lock(0);
    req = "R4"; pulses(127); expect_lock(0);
    req = "R9"; scl = 0; step(1); scl = 1;
    req = "R2"; step(6);
    soft_reset(); expect_lock(0);
    req = "R5"; pulses(100); scl = 0; step(3); scl = 1; step(3);
    pulses(100); expect_lock(0); pulses(28);
    req = "R3"; expect_lock(1);
    req = "R7"; scl = 0; step(5); scl = 1; pulses(10); expect_lock(1);
    soft_reset();
    req = "R6"; pulses(100); av = 1; step(1); av = 0;
    pulses(127); expect_lock(0); pulses(1); expect_lock(1);
    soft_reset();
    req = "R6"; pulses(127); av = 1; vs = 1; step(4); av = 0; vs = 0; step(2);
    expect_lock(0); pulses(127); expect_lock(0); pulses(1); expect_lock(1);
    soft_reset();
    req = "R8"; pulses(127); vs = 1; srst = 1; step(4); srst = 0; vs = 0; step(2);
    expect_lock(0); pulses(128); expect_lock(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule